// File: doc/BRIEF.md
# Single-Word Handshake Buffer

This block holds exactly one data word between a producer and a consumer. Each side talks to it through its own return-to-zero request/acknowledge pair. The producer places a word on the input bus and raises its request. If the slot is empty, the buffer stores the word and acknowledges. The acknowledge is withdrawn only after the producer has withdrawn its request.

Once a word is stored, the buffer shows it on the output bus and raises its own request. When the consumer acknowledges, the buffer withdraws its request. The slot counts as empty again only after the consumer's acknowledge has also returned low. As a result, taking a word in and handing a word out strictly alternate, and no word is overwritten or delivered twice. All logic is on one clock, with a synchronous active-high reset.

Top module: `hs_word_buffer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `in_ack`, `out_req` and `out_data` are all zero after that edge, and the slot is empty.
- R2: `in_ack` rises at an edge only if, at that edge, `in_req` was high, `in_ack` was low and the slot was empty. The word on `in_data` at that edge is the word stored.
- R3: While the slot holds an undelivered word, a high `in_req` does not raise `in_ack`, so the producer waits.
- R4: `in_ack` stays high while `in_req` stays high. It falls at the first edge where `in_req` is sampled low.
- R5: At the edge after a word is stored, `out_req` rises, provided `out_ack` is low.
- R6: `out_data` always shows the most recently stored word. Across an output handshake it equals the word taken at the latest rise of `in_ack`.
- R7: `out_req` stays high while `out_ack` is low. It falls at the first edge where `out_ack` is sampled high.
- R8: `out_req` is not raised while `out_ack` is high. The slot empties at the first edge that samples `out_ack` low after `out_req` has fallen. The next `in_ack` can rise no earlier than the edge after that.
- R9: Rises of `in_ack` and deliveries (rise of `out_ack` while `out_req` is high) alternate, starting with a rise of `in_ack`. Words reach the consumer in the order sent, none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Producer request |
| in_data | input | W (32) | Producer data word |
| in_ack | output | 1 | Buffer acknowledge to the producer |
| out_req | output | 1 | Buffer request to the consumer |
| out_data | output | W (32) | Stored word shown to the consumer |
| out_ack | input | 1 | Consumer acknowledge |

## Verification
On every cycle, the bound checker enforces the acknowledge and request rules of both handshakes, the alternation of acceptances and deliveries, and the match between delivered and accepted data. It does this against its own shadow copy of the accepted word.

Some behaviours appear only in the bench's scenarios:
- the exact cycle counts between events;
- that a producer held off by a full slot really waits through a long, slow consumer handshake;
- that reset in the middle of a transfer drops the word;
- that a run of varied words arrives in order.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_OFFER = 2'd1,
    OUT_DRAIN = 2'd2
  } out_phase_e;

  // producer word may be taken: request up, own ack down, slot empty
  function automatic logic may_accept(input logic held, input logic ack_q, input logic req);
    return req && !ack_q && !held;
  endfunction

  // a stored word may be offered once the consumer ack has returned low
  function automatic logic may_offer(input logic held, input logic ack_in, input out_phase_e ph);
    return (ph == OUT_IDLE) && held && !ack_in;
  endfunction

endpackage

// File: rtl/hsb_in_port.sv
module hsb_in_port
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic held,
  output logic ack,
  output logic take
);

  logic ack_q;

  assign take = may_accept(held, ack_q, req);
  assign ack  = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
    end else if (take) begin
      ack_q <= 1'b1;
    end else if (ack_q && !req) begin
      ack_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hsb_slot.sv
module hsb_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         clear,
  output logic         full,
  output logic [W-1:0] word
);

  logic         full_q;
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      word_q <= din;
    end else if (clear) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign word = word_q;

endmodule

// File: rtl/hsb_out_port.sv
module hsb_out_port
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic held,
  input  logic ack_in,
  output logic req_out,
  output logic deliver,
  output logic done
);

  out_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      OUT_IDLE:  if (may_offer(held, ack_in, ph_q)) ph_d = OUT_OFFER;
      OUT_OFFER: if (ack_in)  ph_d = OUT_DRAIN;
      OUT_DRAIN: if (!ack_in) ph_d = OUT_IDLE;
      default:   ph_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= OUT_IDLE;
    else     ph_q <= ph_d;
  end

  assign req_out = (ph_q == OUT_OFFER);
  assign deliver = (ph_q == OUT_OFFER) && ack_in;
  assign done    = (ph_q == OUT_DRAIN) && !ack_in;

endmodule

// File: rtl/hs_word_buffer.sv
module hs_word_buffer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  output logic         in_ack,
  output logic         out_req,
  output logic [W-1:0] out_data,
  input  logic         out_ack
);

  // named internal events, used by the bound checker
  logic         take_evt;
  logic         deliver_evt;
  logic         done_evt;
  logic         full;
  logic [W-1:0] word;

  hsb_in_port u_in (
    .clk  (clk),
    .rst  (rst),
    .req  (in_req),
    .held (full),
    .ack  (in_ack),
    .take (take_evt)
  );

  hsb_slot #(.W(W)) u_slot (
    .clk   (clk),
    .rst   (rst),
    .load  (take_evt),
    .din   (in_data),
    .clear (done_evt),
    .full  (full),
    .word  (word)
  );

  hsb_out_port u_out (
    .clk     (clk),
    .rst     (rst),
    .held    (full),
    .ack_in  (out_ack),
    .req_out (out_req),
    .deliver (deliver_evt),
    .done    (done_evt)
  );

  assign out_data = word;

endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_req,
  input logic [W-1:0] in_data,
  input logic         in_ack,
  input logic         out_req,
  input logic [W-1:0] out_data,
  input logic         out_ack,
  input logic         take_evt,
  input logic         deliver_evt,
  input logic         done_evt,
  input logic         full
);

  logic         iack_q, oack_q, pend_q;
  logic [W-1:0] din_q, shadow_q;

  logic acc_now, del_now;
  assign acc_now = in_ack && !iack_q;
  assign del_now = out_ack && !oack_q && out_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      iack_q   <= 1'b0;
      oack_q   <= 1'b0;
      pend_q   <= 1'b0;
      din_q    <= '0;
      shadow_q <= '0;
    end else begin
      iack_q <= in_ack;
      oack_q <= out_ack;
      din_q  <= in_data;
      if (acc_now) shadow_q <= din_q;
      if (acc_now)      pend_q <= 1'b1;
      else if (del_now) pend_q <= 1'b0;
    end
  end

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(in_req));
  assert_take_acks_R2: assert property (@(posedge clk) disable iff (rst)
    take_evt |=> (in_ack && full));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    acc_now |-> !pend_q);
  assert_ack_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ack && in_req) |=> in_ack);
  assert_offer_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_now && !out_ack) |=> out_req);
  assert_data_match_R6: assert property (@(posedge clk) disable iff (rst)
    out_req |-> (out_data == shadow_q));
  assert_req_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_ack) |=> out_req);
  assert_req_drops_R7: assert property (@(posedge clk) disable iff (rst)
    deliver_evt |=> !out_req);
  assert_no_raise_under_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (!out_req && out_ack) |=> !out_req);
  assert_empty_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (!full && !out_req));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    del_now |-> pend_q);

endmodule

bind hs_word_buffer hsb_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_req      (in_req),
  .in_data     (in_data),
  .in_ack      (in_ack),
  .out_req     (out_req),
  .out_data    (out_data),
  .out_ack     (out_ack),
  .take_evt    (take_evt),
  .deliver_evt (deliver_evt),
  .done_evt    (done_evt),
  .full        (full)
);

// File: tb/hs_word_buffer_test.sv
module hs_word_buffer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_req = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ack = 1'b0;
  logic        in_ack, out_req;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hs_word_buffer uut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  // behavioural reference: a queue stands for the slot
  bit [31:0] slotq[$];
  bit        m_ack;
  int        m_phase;   // 0 waiting, 1 offering, 2 waiting for consumer release
  bit [31:0] m_word;
  bit        was_empty;

  always @(posedge clk) begin
    if (rst) begin
      slotq.delete();
      m_ack = 0; m_phase = 0; m_word = '0;
    end else begin
      was_empty = (slotq.size() == 0);
      if (!m_ack && in_req && was_empty) begin
        m_ack = 1;
        slotq.push_back(in_data);
        m_word = in_data;
      end else if (m_ack && !in_req) begin
        m_ack = 0;
      end
      if (m_phase == 0) begin
        if (!was_empty && !out_ack) m_phase = 1;
      end else if (m_phase == 1) begin
        if (out_ack) m_phase = 2;
      end else begin
        if (!out_ack) begin
          m_phase = 0;
          void'(slotq.pop_front());
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare with the reference every cycle
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(in_ack == m_ack, "R2 in_ack vs model", 32'(in_ack), 32'(m_ack));
      chk(out_req == (m_phase == 1), "R7 out_req vs model", 32'(out_req), 32'(m_phase == 1));
      chk(out_data == m_word, "R6 out_data vs model", out_data, m_word);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic put(input logic [31:0] w);
    int g;
    in_data = w; in_req = 1'b1;
    g = 0;
    while (!in_ack && g < 200) begin step(); g++; end
    in_req = 1'b0;
    g = 0;
    while (in_ack && g < 200) begin step(); g++; end
  endtask

  task automatic take(output logic [31:0] w, input int hold);
    int g;
    g = 0;
    while (!out_req && g < 200) begin step(); g++; end
    step(hold);
    w = out_data;
    out_ack = 1'b1;
    g = 0;
    while (out_req && g < 200) begin step(); g++; end
    step(hold);
    out_ack = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] got, seed;
    step(3);
    // R1 reset state
    chk(in_ack == 0,   "R1 in_ack reset",  32'(in_ack), 0);
    chk(out_req == 0,  "R1 out_req reset", 32'(out_req), 0);
    chk(out_data == 0, "R1 out_data reset", out_data, 0);
    rst = 1'b0;
    step();

    // basic acceptance and offer
    in_data = 32'hA5A5_0001; in_req = 1'b1;
    step();
    chk(in_ack == 1,  "R2 ack after capture", 32'(in_ack), 1);
    chk(out_req == 0, "R5 no offer yet", 32'(out_req), 0);
    step();
    chk(out_req == 1, "R5 offer one edge later", 32'(out_req), 1);
    chk(out_data == 32'hA5A5_0001, "R6 word shown", out_data, 32'hA5A5_0001);
    chk(in_ack == 1,  "R4 ack held while req high", 32'(in_ack), 1);
    in_req = 1'b0;
    step();
    chk(in_ack == 0,  "R4 ack drops after req low", 32'(in_ack), 0);

    // overflow attempt while the consumer is slow
    in_data = 32'h0000_BEEF; in_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(in_ack == 0,  "R3 producer held off", 32'(in_ack), 0);
      chk(out_req == 1, "R7 req held without ack", 32'(out_req), 1);
      chk(out_data == 32'hA5A5_0001, "R6 word kept", out_data, 32'hA5A5_0001);
    end
    out_ack = 1'b1;
    step();
    chk(out_req == 0, "R7 req drops after ack", 32'(out_req), 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(out_req == 0, "R8 no raise under ack", 32'(out_req), 0);
      chk(in_ack == 0,  "R3 slot still held", 32'(in_ack), 0);
    end
    out_ack = 1'b0;
    step();
    chk(in_ack == 0, "R8 slot empties this edge", 32'(in_ack), 0);
    step();
    chk(in_ack == 1, "R9 next accept after release", 32'(in_ack), 1);
    step();
    chk(out_req == 1, "R5 second offer", 32'(out_req), 1);
    chk(out_data == 32'h0000_BEEF, "R6 second word", out_data, 32'h0000_BEEF);
    in_req = 1'b0;
    step();
    take(got, 2);
    chk(got == 32'h0000_BEEF, "R9 second word delivered", got, 32'h0000_BEEF);

    // a run of words with varied consumer pacing
    seed = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      seed = seed * 32'd1664525 + 32'd1013904223;
      w = seed;
      put(w);
      take(got, i % 4);
      chk(got == w, "R9 ordered delivery", got, w);
    end

    // reset in the middle of a transfer
    in_data = 32'hDEAD_0042; in_req = 1'b1;
    step(2);
    rst = 1'b1; in_req = 1'b0;
    step();
    chk(in_ack == 0,   "R1 ack cleared mid-transfer", 32'(in_ack), 0);
    chk(out_req == 0,  "R1 req cleared mid-transfer", 32'(out_req), 0);
    chk(out_data == 0, "R1 word cleared mid-transfer", out_data, 0);
    rst = 1'b0;
    step(2);
    chk(out_req == 0, "R1 slot empty after reset", 32'(out_req), 0);
    put(32'h7777_0003);
    take(got, 1);
    chk(got == 32'h7777_0003, "R9 works after reset", got, 32'h7777_0003);

    step(2);
    report();
  end

endmodule